// File: doc/BRIEF.md
# Serial Management Bus Master

This block is a memory-mapped master for a two-wire serial management bus (MDC clock, bidirectional MDIO data) that reaches the control registers of a SerDes PHY. Software programs a control word (clock divisor, preamble enable, PHY-select mode), then writes a 32-bit frame word into the data register. That write starts a transaction. The block shifts the frame word out MSB first, one bit per MDC period. On a read frame it releases the data line and collects the 16-bit answer. When the last bit period ends, it raises a completion flag.

The frame word is sent as written: bits 31:30 carry the start pattern and bits 29:28 the opcode. The addresses sit below them, bits 17:16 are the turnaround and bits 15:0 the data. The block therefore works with either field layout that software uses. An optional PHY-select mode splits one request into two frames. The first is an automatically built write frame that names the PHY. The second is the original frame with its PHY field cleared. A zero write to the control register aborts any frame in flight and turns the session off.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset MDC is low, MDIO is released (mdioOe low), and both the control register (offset 0x128) and the data register (offset 0x12C) read zero.
- R2: The control register reads the divisor in bits 6:0, preamble enable in bit 7, the completion flag in bit 8 and PHY-select mode in bit 9, with other bits zero. The data register reads the last returned read value in bits 15:0 with bits 31:16 zero. Any other offset reads zero.
- R3: While a frame is active, MDC has a period of 2*(divisor+1) clock cycles and starts each bit low. While idle, MDC stays low.
- R4: A data-register write with bit 30 set while idle starts a frame. A data-register write with bit 30 clear produces no MDC activity. A data-register write during an active frame is ignored.
- R5: With control bit 7 set, every frame is preceded by 32 bit periods of MDIO driven high. With bit 7 clear, no preamble is sent.
- R6: The 32 bits of the frame word go out MSB first, one per MDC period. MDIO changes only after the falling MDC edge and is stable at the rising edge.
- R7: A frame with bit 29 set is a read. Bits 31:18 are driven, and MDIO is then released for the last 18 bit periods. The 16 bits seen at the rising MDC edges of bit times 15..0 are stored MSB first and become readable in data bits 15:0 when the frame completes.
- R8: The completion flag (control bit 8) clears when a frame starts and sets when the last bit period ends. Software writes to bit 8 have no effect.
- R9: With control bit 9 set, a started frame first sends a write frame. That frame has bits 31:28 = 0101, bits 22:18 all ones, bits 17:16 = 10, and the PHY number taken from bits 27:23 of the written word placed at bits 8:4, with all other bits zero. The written word then follows with bits 27:23 cleared. The completion flag sets only after the second frame.
- R10: Writing zero to the control register aborts an active frame. MDC returns low, MDIO is released, the flag and configuration clear, and the read data is left unchanged. A nonzero control write during a frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | ADDR_W | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | Data value driven onto MDIO |
| mdioOe | output | 1 | Output enable for MDIO; low means released |
| mdioIn | input | 1 | Data value seen on MDIO |

## Verification
The bench acts as the PHY: it records every rising MDC edge together with the data line and its enable, and answers reads in the released window. A mis-timed turnaround shows up as a shifted or bit-reversed read value, and a preamble off by one bit period shows up as a wrong stream length. The bench also goes after a start write landing during a busy frame, which a faulty design would let corrupt the shifted word or the returned data. It covers an abort in the middle of a read, where a faulty design leaves MDC toggling or clobbers the stored read value. PHY-select mode is checked for the order of the two frames and for the PHY number moving from bits 27:23 to bits 8:4.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int FRAME_BITS   = 32;
  localparam int OFS_CTRL     = 'h128;
  localparam int OFS_DATA     = 'h12C;

  localparam int CTRL_PRE_POS  = 7;
  localparam int CTRL_DONE_POS = 8;
  localparam int CTRL_SEL_POS  = 9;

  localparam int START_POS    = 30;
  localparam int READ_POS     = 29;
  localparam int PHY_HI       = 27;
  localparam int PHY_LO       = 23;
  localparam int RELEASE_FROM = 17;
  localparam int DATA_HI      = 15;
  localparam int RD_W         = DATA_HI + 1;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PRE   = 2'd1,
    PH_FRAME = 2'd2
  } phase_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadFirst;
    logic loadSecond;
    logic sample;
    logic latchRead;
  } dpCmd_t;

  // write frame that names the PHY ahead of the real transfer
  function automatic logic [FRAME_BITS-1:0] selectWord(input logic [PHY_HI-PHY_LO:0] phy);
    logic [FRAME_BITS-1:0] w;
    w        = '0;
    w[31:30] = 2'b01;
    w[29:28] = 2'b01;
    w[22:18] = 5'h1F;
    w[17:16] = 2'b10;
    w[8:4]   = phy;
    return w;
  endfunction

  function automatic logic [FRAME_BITS-1:0] stripPhy(input logic [FRAME_BITS-1:0] w);
    logic [FRAME_BITS-1:0] r;
    r = w;
    r[PHY_HI:PHY_LO] = '0;
    return r;
  endfunction

endpackage

// File: rtl/mdio_mgmt_clkdiv.sv
module mdio_mgmt_clkdiv #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] divVal,
  output logic             mdc,
  output logic             riseTick,
  output logic             fallTick
);

  logic [DIV_W-1:0] halfCnt;
  logic             halfDone;

  assign halfDone = run && (halfCnt == divVal);
  assign riseTick = halfDone && !mdc;
  assign fallTick = halfDone && mdc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt <= '0;
      mdc     <= 1'b0;
    end else if (!run) begin
      halfCnt <= '0;
      mdc     <= 1'b0;
    end else if (halfDone) begin
      halfCnt <= '0;
      mdc     <= ~mdc;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  AST_MDC_HALF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (run && $past(run) && !$past(halfDone)) |-> $stable(mdc)); // R3

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameWr,
  input  logic       frameWrStart,
  input  logic       ctrlWr,
  input  logic       ctrlWrZero,
  input  logic       preEn,
  input  logic       selMode,
  input  logic       isRead,
  input  logic       riseTick,
  input  logic       fallTick,
  output logic       busy,
  output logic       done,
  output logic       inPre,
  output logic [4:0] bitIdx,
  output dpCmd_t     cmd
);

  localparam int CNT_W = $clog2((PRE_LEN > FRAME_BITS) ? PRE_LEN : FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_FRAME = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_PRE   = CNT_W'(PRE_LEN - 1);
  localparam logic [CNT_W-1:0] DATA_TOP   = CNT_W'(DATA_HI);

  phase_t           phase;
  logic [CNT_W-1:0] bitCnt;
  logic             selPending;
  logic             abortReq;
  logic             startReq;
  logic             frameEnd;

  assign abortReq = ctrlWr && ctrlWrZero;
  assign startReq = frameWr && frameWrStart && (phase == PH_IDLE) && !abortReq;
  assign frameEnd = (phase == PH_FRAME) && fallTick && (bitCnt == '0);

  assign busy   = (phase != PH_IDLE);
  assign inPre  = (phase == PH_PRE);
  assign bitIdx = bitCnt[4:0];

  always_comb begin
    cmd            = '0;
    cmd.loadFirst  = startReq;
    cmd.loadSecond = !abortReq && frameEnd && selPending;
    cmd.latchRead  = !abortReq && frameEnd && !selPending && isRead;
    cmd.sample     = !abortReq && (phase == PH_FRAME) && riseTick && isRead
                     && (bitCnt <= DATA_TOP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      bitCnt     <= '0;
      selPending <= 1'b0;
      done       <= 1'b0;
    end else if (abortReq) begin
      phase      <= PH_IDLE;
      bitCnt     <= '0;
      selPending <= 1'b0;
      done       <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (startReq) begin
            done       <= 1'b0;
            selPending <= selMode;
            phase      <= preEn ? PH_PRE : PH_FRAME;
            bitCnt     <= preEn ? LAST_PRE : LAST_FRAME;
          end
        end
        PH_PRE: begin
          if (fallTick) begin
            if (bitCnt == '0) begin
              phase  <= PH_FRAME;
              bitCnt <= LAST_FRAME;
            end else begin
              bitCnt <= bitCnt - 1'b1;
            end
          end
        end
        PH_FRAME: begin
          if (fallTick) begin
            if (bitCnt == '0) begin
              if (selPending) begin
                selPending <= 1'b0;
                phase      <= preEn ? PH_PRE : PH_FRAME;
                bitCnt     <= preEn ? LAST_PRE : LAST_FRAME;
              end else begin
                phase <= PH_IDLE;
                done  <= 1'b1;
              end
            end else begin
              bitCnt <= bitCnt - 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_DONE_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(phase == PH_FRAME && fallTick)); // R8

  AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done); // R8

  AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.loadFirst, cmd.loadSecond, cmd.latchRead})); // R9

endmodule

// File: rtl/mdio_mgmt_datapath.sv
module mdio_mgmt_datapath
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DIV_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              busy,
  input  logic              done,
  input  logic              inPre,
  input  logic [4:0]        bitIdx,
  input  dpCmd_t            cmd,
  input  logic              mdioIn,
  output logic [DIV_W-1:0]  divVal,
  output logic              preEn,
  output logic              selMode,
  output logic              isRead,
  output logic              frameWr,
  output logic              frameWrStart,
  output logic              ctrlWr,
  output logic              ctrlWrZero,
  output logic              mdioOut,
  output logic              mdioOe
);

  localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] ADR_DATA = ADDR_W'(OFS_DATA);
  localparam logic [4:0]        REL_TOP  = 5'(RELEASE_FROM);

  logic                  hitCtrl;
  logic                  hitData;
  logic [FRAME_BITS-1:0] heldWord;
  logic [FRAME_BITS-1:0] activeWord;
  logic [RD_W-1:0]       capSr;
  logic [RD_W-1:0]       rdData;
  logic                  releaseWin;

  assign hitCtrl      = (regAddr == ADR_CTRL);
  assign hitData      = (regAddr == ADR_DATA);
  assign ctrlWr       = regWrEn && hitCtrl;
  assign ctrlWrZero   = (regWrData == '0);
  assign frameWr      = regWrEn && hitData;
  assign frameWrStart = regWrData[START_POS];

  // configuration: frozen while a frame runs, except for the zero abort
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divVal  <= '0;
      preEn   <= 1'b0;
      selMode <= 1'b0;
    end else if (ctrlWr && (!busy || ctrlWrZero)) begin
      divVal  <= regWrData[DIV_W-1:0];
      preEn   <= regWrData[CTRL_PRE_POS];
      selMode <= regWrData[CTRL_SEL_POS];
    end
  end

  // frame words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldWord   <= '0;
      activeWord <= '0;
    end else if (cmd.loadFirst) begin
      heldWord   <= regWrData;
      activeWord <= selMode ? selectWord(regWrData[PHY_HI:PHY_LO]) : regWrData;
    end else if (cmd.loadSecond) begin
      activeWord <= stripPhy(heldWord);
    end
  end

  // read capture and result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capSr  <= '0;
      rdData <= '0;
    end else begin
      if (cmd.loadFirst) begin
        capSr <= '0;
      end else if (cmd.sample) begin
        capSr <= {capSr[RD_W-2:0], mdioIn};
      end
      if (cmd.latchRead) begin
        rdData <= capSr;
      end
    end
  end

  assign isRead     = activeWord[READ_POS];
  assign releaseWin = !inPre && isRead && (bitIdx <= REL_TOP);
  assign mdioOe     = busy && !releaseWin;
  assign mdioOut    = mdioOe && (inPre || activeWord[bitIdx]);

  always_comb begin
    regRdData = '0;
    if (hitCtrl) begin
      regRdData[DIV_W-1:0]     = divVal;
      regRdData[CTRL_PRE_POS]  = preEn;
      regRdData[CTRL_DONE_POS] = done;
      regRdData[CTRL_SEL_POS]  = selMode;
    end else if (hitData) begin
      regRdData[RD_W-1:0] = rdData;
    end
  end

  AST_HELD_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(heldWord)); // R4

  AST_SAMPLE_WHEN_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    cmd.sample |-> !mdioOe); // R7

  AST_PREAMBLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    inPre |-> (mdioOe && mdioOut)); // R5

  AST_RDDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cmd.latchRead) |-> $stable(rdData)); // R10

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DIV_W   = 7,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);

  logic             busy;
  logic             done;
  logic             inPre;
  logic [4:0]       bitIdx;
  dpCmd_t           cmd;
  logic [DIV_W-1:0] divVal;
  logic             preEn;
  logic             selMode;
  logic             isRead;
  logic             frameWr;
  logic             frameWrStart;
  logic             ctrlWr;
  logic             ctrlWrZero;
  logic             riseTick;
  logic             fallTick;

  mdio_mgmt_clkdiv #(.DIV_W(DIV_W)) uClk (
    .clk      (clk),
    .rstN     (rstN),
    .run      (busy),
    .divVal   (divVal),
    .mdc      (mdc),
    .riseTick (riseTick),
    .fallTick (fallTick)
  );

  mdio_mgmt_ctrl #(.PRE_LEN(PRE_LEN)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .frameWr      (frameWr),
    .frameWrStart (frameWrStart),
    .ctrlWr       (ctrlWr),
    .ctrlWrZero   (ctrlWrZero),
    .preEn        (preEn),
    .selMode      (selMode),
    .isRead       (isRead),
    .riseTick     (riseTick),
    .fallTick     (fallTick),
    .busy         (busy),
    .done         (done),
    .inPre        (inPre),
    .bitIdx       (bitIdx),
    .cmd          (cmd)
  );

  mdio_mgmt_datapath #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .busy         (busy),
    .done         (done),
    .inPre        (inPre),
    .bitIdx       (bitIdx),
    .cmd          (cmd),
    .mdioIn       (mdioIn),
    .divVal       (divVal),
    .preEn        (preEn),
    .selMode      (selMode),
    .isRead       (isRead),
    .frameWr      (frameWr),
    .frameWrStart (frameWrStart),
    .ctrlWr       (ctrlWr),
    .ctrlWrZero   (ctrlWrZero),
    .mdioOut      (mdioOut),
    .mdioOe       (mdioOe)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> (!mdc && !mdioOe)); // R3

endmodule

// File: tb/mdio_mgmt_master_test.sv
`timescale 1ns/1ps
module mdio_mgmt_master_test;

  localparam logic [11:0] A_CTRL = 12'h128;
  localparam logic [11:0] A_DATA = 12'h12C;
  localparam int          CAP_MAX = 200;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc;
  logic        mdioOut;
  logic        mdioOe;
  logic        mdioIn = 1'b1;

  always #2.5 clk = ~clk;

  mdio_mgmt_master uut (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .mdc       (mdc),
    .mdioOut   (mdioOut),
    .mdioOe    (mdioOe),
    .mdioIn    (mdioIn)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // PHY model, sampled away from the active edge
  logic        prevMdc = 1'b0;
  int          cyc = 0;
  int          capN = 0;
  int          relCount = 0;
  logic        capOe  [CAP_MAX];
  logic        capBit [CAP_MAX];
  int          riseCyc[CAP_MAX];
  logic [15:0] resp = '0;

  logic        expOe  [CAP_MAX];
  logic        expBit [CAP_MAX];
  int          expN = 0;

  always @(negedge clk) begin
    cyc++;
    if (mdc && !prevMdc) begin
      if (capN < CAP_MAX) begin
        capOe[capN]   = mdioOe;
        capBit[capN]  = mdioOut;
        riseCyc[capN] = cyc;
      end
      capN++;
      if (!mdioOe) relCount++;
    end
    if (!mdc && prevMdc) begin
      if (relCount >= 2 && relCount <= 17) mdioIn = resp[17 - relCount];
      else mdioIn = 1'b1;
    end
    prevMdc = mdc;
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic resetModel();
    capN = 0; relCount = 0; expN = 0;
  endtask

  task automatic waitDone(input string req);
    logic [31:0] v;
    bit seen;
    seen = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      rdReg(A_CTRL, v);
      seen = v[8];
    end
    check(req, "completion flag reached", 32'(seen), 32'd1);
  endtask

  task automatic expPre();
    for (int i = 0; i < 32; i++) begin
      expOe[expN] = 1'b1; expBit[expN] = 1'b1; expN++;
    end
  endtask

  task automatic expWord(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) begin
      expOe[expN]  = !(w[29] && i <= 17);
      expBit[expN] = w[i];
      expN++;
    end
  endtask

  task automatic compareStream(input string req);
    int mm;
    mm = 0;
    check(req, "bit periods on the bus", 32'(capN), 32'(expN));
    for (int i = 0; i < expN && i < capN; i++) begin
      if (capOe[i] !== expOe[i]) mm++;
      else if (expOe[i] && capBit[i] !== expBit[i]) mm++;
    end
    check(req, "mismatching bit periods", 32'(mm), 32'd0);
  endtask

  function automatic logic [31:0] selFrame(input logic [4:0] phy);
    return {2'b01, 2'b01, 5'b0, 5'b11111, 2'b10, 7'b0, phy, 4'b0};
  endfunction

  // ---------------- scenarios ----------------
  task automatic testReset();
    logic [31:0] v;
    check("R1", "mdc after reset", 32'(mdc), 32'd0);
    check("R1", "mdioOe after reset", 32'(mdioOe), 32'd0);
    rdReg(A_CTRL, v); check("R1", "control after reset", v, 32'h0);
    rdReg(A_DATA, v); check("R1", "data after reset", v, 32'h0);
    rdReg(12'h130, v); check("R2", "unmapped offset", v, 32'h0);
  endtask

  task automatic testWriteFrame();
    logic [31:0] v;
    logic [31:0] w;
    w = 32'h5096_A5C3;
    wrReg(A_CTRL, 32'h0000_0002);
    rdReg(A_CTRL, v); check("R2", "control readback", v, 32'h0000_0002);
    resetModel();
    wrReg(A_DATA, w);
    rdReg(A_CTRL, v); check("R8", "flag clear after start", v[8], 1'b0);
    waitDone("R8");
    expWord(w);
    compareStream("R6");
    check("R3", "mdc period div2", 32'(riseCyc[1] - riseCyc[0]), 32'd6);
    rdReg(A_CTRL, v); check("R8", "control after write frame", v, 32'h0000_0102);
    @(negedge clk);
    check("R3", "mdc low when idle", 32'(mdc), 32'd0);
  endtask

  task automatic testPreamble();
    logic [31:0] w;
    w = 32'h5123_4567;
    wrReg(A_CTRL, 32'h0000_0080);
    resetModel();
    wrReg(A_DATA, w);
    waitDone("R5");
    expPre(); expWord(w);
    compareStream("R5");
    check("R3", "mdc period div0", 32'(riseCyc[1] - riseCyc[0]), 32'd2);
  endtask

  task automatic testRead();
    logic [31:0] v;
    logic [31:0] w;
    w = 32'h61A6_0000;
    resp = 16'hB2D9;
    wrReg(A_CTRL, 32'h0000_0081);
    resetModel();
    wrReg(A_DATA, w);
    waitDone("R7");
    expPre(); expWord(w);
    compareStream("R7");
    rdReg(A_DATA, v); check("R7", "returned read data", v, 32'h0000_B2D9);
    check("R3", "mdc period div1", 32'(riseCyc[3] - riseCyc[2]), 32'd4);
  endtask

  task automatic testIgnoredStarts();
    logic [31:0] v;
    logic [31:0] w;
    wrReg(A_CTRL, 32'h0000_0001);
    resetModel();
    wrReg(A_DATA, 32'h1096_A5C3);
    repeat (40) @(negedge clk);
    check("R4", "no MDC without start bit", 32'(capN), 32'd0);
    rdReg(A_CTRL, v); check("R4", "flag kept without start bit", v, 32'h0000_0101);
    w = 32'h5096_A5C3;
    resetModel();
    wrReg(A_DATA, w);
    repeat (10) @(negedge clk);
    wrReg(A_DATA, 32'h6FFF_0000);
    waitDone("R4");
    expWord(w);
    compareStream("R4");
    rdReg(A_DATA, v); check("R4", "read data untouched by busy write", v, 32'h0000_B2D9);
  endtask

  task automatic testSelect();
    logic [31:0] v;
    logic [31:0] w;
    logic [4:0]  phy;
    logic [31:0] mainW;
    phy = 5'b10110;
    w = {4'b0110, phy, 5'b00101, 2'b10, 16'h0000};
    mainW = w;
    mainW[27:23] = 5'b0;
    resp = 16'h3C5A;
    wrReg(A_CTRL, 32'h0000_0200);
    resetModel();
    wrReg(A_DATA, w);
    waitDone("R9");
    expWord(selFrame(phy)); expWord(mainW);
    compareStream("R9");
    rdReg(A_DATA, v); check("R9", "read data after select pair", v, 32'h0000_3C5A);
    rdReg(A_CTRL, v); check("R2", "control with select mode", v, 32'h0000_0300);
  endtask

  task automatic testAbort();
    logic [31:0] v;
    int snap;
    resp = 16'hFFFF;
    wrReg(A_CTRL, 32'h0000_0003);
    resetModel();
    wrReg(A_DATA, 32'h61A6_0000);
    repeat (28) @(negedge clk);
    wrReg(A_CTRL, 32'h0000_007F);
    rdReg(A_CTRL, v); check("R10", "nonzero control write while busy", v, 32'h0000_0003);
    repeat (30) @(negedge clk);
    check("R10", "mdc period kept", 32'(riseCyc[6] - riseCyc[5]), 32'd8);
    wrReg(A_CTRL, 32'h0000_0000);
    @(negedge clk);
    check("R10", "mdc low after abort", 32'(mdc), 32'd0);
    check("R10", "mdio released after abort", 32'(mdioOe), 32'd0);
    rdReg(A_CTRL, v); check("R10", "control after abort", v, 32'h0);
    rdReg(A_DATA, v); check("R10", "read data kept after abort", v, 32'h0000_3C5A);
    snap = capN;
    repeat (40) @(negedge clk);
    check("R10", "no MDC edges after abort", 32'(capN), 32'(snap));
  endtask

  task automatic testFlagReadOnly();
    logic [31:0] v;
    wrReg(A_CTRL, 32'h0000_0102);
    rdReg(A_CTRL, v); check("R8", "flag not writable", v, 32'h0000_0002);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWriteFrame();
    testPreamble();
    testRead();
    testIgnoredStarts();
    testSelect();
    testAbort();
    testFlagReadOnly();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule